// File: doc/BRIEF.md
# Bidirectional Multi-Mode Shift Register

This block is an N-bit register, 4 bits by default. On each rising clock edge it does one of four things: it keeps its value, it loads a parallel word, it moves its contents one place toward bit 0, or it moves them one place toward the most significant bit. A separate two-bit kind select sets the bit that fills the vacated end during a shift. That bit is a zero for a logical shift, a copy of the sign bit for an arithmetic shift toward bit 0, the bit that leaves the other end for a rotate, or an external serial bit.

A second output holds the bit that left the register on the most recent shift. A datapath can therefore pass that bit on to a neighbouring register, or use it as a carry or status bit. A synchronous active-high reset clears both the register and that output, and it overrides every mode.

Top module: `univ_shift_reg`

## Requirements
- R1: While `rst` is high at a rising edge, `regOut` becomes all zeros and `shiftOut` becomes 0, whatever the mode.
- R2: Mode code 00 (hold) leaves `regOut` and `shiftOut` unchanged, whatever the kind select and the serial inputs are.
- R3: Mode code 11 (load) copies `parIn` into `regOut` at the edge and leaves `shiftOut` unchanged.
- R4: Mode code 01 shifts toward bit 0. With kind 00 (logical) a 0 enters the MSB, so 0100 becomes 0010 and 1110 becomes 0111.
- R5: Mode 01 with kind 01 (arithmetic) keeps the old MSB in the MSB, so 1110 becomes 1111 and 0100 becomes 0010.
- R6: Mode 01 with kind 10 (rotate) moves the old bit 0 into the MSB, so 0101 becomes 1010 and 1110 becomes 0111.
- R7: Mode code 10 shifts toward the MSB. With kind 00 a 0 enters bit 0, so 0011 becomes 0110.
- R8: Mode 10 with kind 01 gives the same result as a logical shift toward the MSB, so 1101 becomes 1010.
- R9: Mode 10 with kind 10 moves the old MSB into bit 0, so 1001 becomes 0011.
- R10: Kind 11 (serial fill) puts `serInDown` into the MSB on a mode-01 shift and `serInUp` into bit 0 on a mode-10 shift.
- R11: On every shift cycle `shiftOut` takes the bit that left the register: the old bit 0 for mode 01 and the old MSB for mode 10. On all other cycles it keeps its value.
- R12: With kinds 00, 01 and 10 the serial inputs have no effect on `regOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| modeSel | input | 2 | 00 hold, 01 shift toward bit 0, 10 shift toward MSB, 11 parallel load |
| kindSel | input | 2 | 00 logical, 01 arithmetic, 10 rotate, 11 serial fill |
| serInDown | input | 1 | Fill bit for the MSB on a serial-fill shift toward bit 0 |
| serInUp | input | 1 | Fill bit for bit 0 on a serial-fill shift toward the MSB |
| parIn | input | W | Parallel load data |
| regOut | output | W | Register contents |
| shiftOut | output | 1 | Bit that left the register on the last shift |

## Verification
Both outputs come straight from flip-flops. The inputs set before a rising edge show up on `regOut` and `shiftOut` after that edge and no earlier, so each result is due exactly one cycle after its stimulus. The driver applies each operation on a falling edge and queues the value expected after the next rising edge. The monitor pops that item a quarter period after the rising edge, away from both clock edges. Hold steps are repeated and include toggled serial inputs, which shows that nothing drifts across cycles in which the register is not meant to change.

// File: rtl/usr_pkg.sv
package usr_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_DOWN = 2'b01,
    MODE_UP   = 2'b10,
    MODE_LOAD = 2'b11
  } modeE;

  typedef enum logic [1:0] {
    KIND_LOGIC = 2'b00,
    KIND_ARITH = 2'b01,
    KIND_ROT   = 2'b10,
    KIND_FILL  = 2'b11
  } kindE;

  typedef struct packed {
    logic clr;
    logic load;
    logic shift;
    logic dirUp;
    kindE kind;
  } strobeS;

endpackage

// File: rtl/usr_ctrl.sv
module usr_ctrl
  import usr_pkg::*;
(
  input  logic       rst,
  input  logic [1:0] modeSel,
  input  logic [1:0] kindSel,
  output strobeS     strobes
);

  modeE modeQ;

  always_comb begin
    modeQ         = modeE'(modeSel);
    strobes.clr   = rst;
    strobes.load  = !rst && (modeQ == MODE_LOAD);
    strobes.shift = !rst && ((modeQ == MODE_DOWN) || (modeQ == MODE_UP));
    strobes.dirUp = (modeQ == MODE_UP);
    strobes.kind  = kindE'(kindSel);
  end

endmodule

// File: rtl/usr_datapath.sv
module usr_datapath
  import usr_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  strobeS       strobes,
  input  logic         serInDown,
  input  logic         serInUp,
  input  logic [W-1:0] parIn,
  output logic [W-1:0] regQ,
  output logic         outBitQ
);

  localparam int MSB = W - 1;

  logic [W-1:0] regD;
  logic         fillHi;
  logic         fillLo;
  logic         leaveBit;

  // End-fill selection for each direction
  always_comb begin
    unique case (strobes.kind)
      KIND_LOGIC: begin fillHi = 1'b0;      fillLo = 1'b0;      end
      KIND_ARITH: begin fillHi = regQ[MSB]; fillLo = 1'b0;      end
      KIND_ROT:   begin fillHi = regQ[0];   fillLo = regQ[MSB]; end
      default:    begin fillHi = serInDown; fillLo = serInUp;   end
    endcase
    leaveBit = strobes.dirUp ? regQ[MSB] : regQ[0];
  end

  // One stage per bit: keep, take a neighbour, or take parallel data
  for (genvar i = 0; i < W; i++) begin : gStage
    logic fromBelow;
    logic fromAbove;
    if (i == 0) begin : gLow
      assign fromBelow = fillLo;
    end else begin : gLowN
      assign fromBelow = regQ[i-1];
    end
    if (i == MSB) begin : gHigh
      assign fromAbove = fillHi;
    end else begin : gHighN
      assign fromAbove = regQ[i+1];
    end
    always_comb begin
      if (strobes.clr)        regD[i] = 1'b0;
      else if (strobes.load)  regD[i] = parIn[i];
      else if (strobes.shift) regD[i] = strobes.dirUp ? fromBelow : fromAbove;
      else                    regD[i] = regQ[i];
    end
  end

  always_ff @(posedge clk) begin
    regQ <= regD;
    if (strobes.clr)        outBitQ <= 1'b0;
    else if (strobes.shift) outBitQ <= leaveBit;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    strobes.clr |=> (regQ == '0 && outBitQ == 1'b0));

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (strobes.clr)
    (!strobes.load && !strobes.shift) |=> ($stable(regQ) && $stable(outBitQ)));

  // R3
  load_copy_chk: assert property (@(posedge clk) disable iff (strobes.clr)
    strobes.load |=> (regQ == $past(parIn) && $stable(outBitQ)));

  // R11
  down_out_chk: assert property (@(posedge clk) disable iff (strobes.clr)
    (strobes.shift && !strobes.dirUp) |=> (outBitQ == $past(regQ[0])));

  // R11
  up_out_chk: assert property (@(posedge clk) disable iff (strobes.clr)
    (strobes.shift && strobes.dirUp) |=> (outBitQ == $past(regQ[MSB])));

  // R5
  arith_sign_chk: assert property (@(posedge clk) disable iff (strobes.clr)
    (strobes.shift && !strobes.dirUp && strobes.kind == KIND_ARITH)
      |=> (regQ[MSB] == $past(regQ[MSB])));

  // R7
  up_logic_low_chk: assert property (@(posedge clk) disable iff (strobes.clr)
    (strobes.shift && strobes.dirUp && strobes.kind == KIND_LOGIC)
      |=> (regQ[0] == 1'b0));

endmodule

// File: rtl/univ_shift_reg.sv
module univ_shift_reg
  import usr_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   modeSel,
  input  logic [1:0]   kindSel,
  input  logic         serInDown,
  input  logic         serInUp,
  input  logic [W-1:0] parIn,
  output logic [W-1:0] regOut,
  output logic         shiftOut
);

  strobeS strobes;

  usr_ctrl uCtrl (
    .rst     (rst),
    .modeSel (modeSel),
    .kindSel (kindSel),
    .strobes (strobes)
  );

  usr_datapath #(.W(W)) uPath (
    .clk       (clk),
    .strobes   (strobes),
    .serInDown (serInDown),
    .serInUp   (serInUp),
    .parIn     (parIn),
    .regQ      (regOut),
    .outBitQ   (shiftOut)
  );

endmodule

// File: tb/sim_univ_shift_reg.sv
module sim_univ_shift_reg;

  localparam int PERIOD = 10;
  localparam int W = 4;

  typedef struct {
    logic [W-1:0] expQ;
    logic         expSo;
    string        tag;
  } itemS;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   modeSel = 2'b00;
  logic [1:0]   kindSel = 2'b00;
  logic         serInDown = 1'b0;
  logic         serInUp = 1'b0;
  logic [W-1:0] parIn = '0;
  logic [W-1:0] regOut;
  logic         shiftOut;

  int checks = 0;
  int fails = 0;
  itemS sb[$];

  always #(PERIOD/2) clk = ~clk;

  univ_shift_reg #(.W(W)) u0 (
    .clk(clk), .rst(rst), .modeSel(modeSel), .kindSel(kindSel),
    .serInDown(serInDown), .serInUp(serInUp), .parIn(parIn),
    .regOut(regOut), .shiftOut(shiftOut)
  );

  task automatic step(input logic r, input logic [1:0] m, input logic [1:0] k,
                      input logic sd, input logic su, input logic [W-1:0] p,
                      input logic [W-1:0] eq, input logic es, input string tag);
    itemS it;
    @(negedge clk);
    rst = r; modeSel = m; kindSel = k; serInDown = sd; serInUp = su; parIn = p;
    it.expQ = eq; it.expSo = es; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic monitor();
    forever begin
      @(posedge clk);
      #(PERIOD/4);
      if (sb.size() > 0) begin
        itemS it;
        it = sb.pop_front();
        checks++;
        if (regOut !== it.expQ || shiftOut !== it.expSo) begin
          fails++;
          $display("FAIL %s: regOut=%b shiftOut=%b expected regOut=%b shiftOut=%b",
                   it.tag, regOut, shiftOut, it.expQ, it.expSo);
        end
      end
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(PERIOD * 5000);
    checks++;
    fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    finishRun();
  end

  initial begin
    fork monitor(); join_none
    // R1 reset beats load
    step(1, 2'b11, 2'b00, 0, 0, 4'b1111, 4'b0000, 0, "R1 reset");
    step(0, 2'b11, 2'b00, 0, 0, 4'b0100, 4'b0100, 0, "R3 load");
    step(0, 2'b01, 2'b00, 0, 0, 4'b0000, 4'b0010, 0, "R4 down logical 0100");
    step(0, 2'b11, 2'b00, 0, 0, 4'b1110, 4'b1110, 0, "R3 load");
    step(0, 2'b01, 2'b00, 0, 0, 4'b0000, 4'b0111, 0, "R4 down logical 1110");
    step(0, 2'b11, 2'b00, 0, 0, 4'b1110, 4'b1110, 0, "R3 load");
    step(0, 2'b01, 2'b01, 0, 0, 4'b0000, 4'b1111, 0, "R5 down arith 1110");
    step(0, 2'b01, 2'b01, 0, 0, 4'b0000, 4'b1111, 1, "R5 down arith 1111");
    step(0, 2'b11, 2'b01, 0, 0, 4'b0100, 4'b0100, 1, "R3 load keeps shiftOut");
    step(0, 2'b01, 2'b01, 0, 0, 4'b0000, 4'b0010, 0, "R5 down arith 0100");
    step(0, 2'b11, 2'b00, 0, 0, 4'b0101, 4'b0101, 0, "R3 load");
    step(0, 2'b01, 2'b10, 0, 0, 4'b0000, 4'b1010, 1, "R6 rotate down 0101");
    step(0, 2'b11, 2'b00, 0, 0, 4'b1110, 4'b1110, 1, "R3 load");
    step(0, 2'b01, 2'b10, 0, 0, 4'b0000, 4'b0111, 0, "R6 rotate down 1110");
    step(0, 2'b11, 2'b00, 0, 0, 4'b0011, 4'b0011, 0, "R3 load");
    step(0, 2'b10, 2'b00, 0, 0, 4'b0000, 4'b0110, 0, "R7 up logical 0011");
    step(0, 2'b10, 2'b00, 0, 0, 4'b0000, 4'b1100, 0, "R7 up logical 0110");
    step(0, 2'b10, 2'b00, 0, 0, 4'b0000, 4'b1000, 1, "R11 up shiftOut MSB");
    step(0, 2'b11, 2'b00, 0, 0, 4'b1101, 4'b1101, 1, "R3 load");
    step(0, 2'b10, 2'b01, 0, 0, 4'b0000, 4'b1010, 1, "R8 up arith 1101");
    step(0, 2'b11, 2'b00, 0, 0, 4'b1001, 4'b1001, 1, "R3 load");
    step(0, 2'b10, 2'b10, 0, 0, 4'b0000, 4'b0011, 1, "R9 rotate up 1001");
    step(0, 2'b11, 2'b00, 0, 0, 4'b0000, 4'b0000, 1, "R3 load zero");
    step(0, 2'b01, 2'b11, 1, 0, 4'b0000, 4'b1000, 0, "R10 fill down");
    step(0, 2'b10, 2'b11, 0, 1, 4'b0000, 4'b0001, 1, "R10 fill up");
    step(0, 2'b00, 2'b11, 1, 1, 4'b1111, 4'b0001, 1, "R2 hold");
    step(0, 2'b00, 2'b10, 0, 0, 4'b1010, 4'b0001, 1, "R2 hold");
    step(0, 2'b01, 2'b00, 1, 1, 4'b0000, 4'b0000, 1, "R12 down logical serial ignored");
    step(0, 2'b11, 2'b00, 1, 1, 4'b0110, 4'b0110, 1, "R3 load");
    step(0, 2'b10, 2'b00, 1, 1, 4'b0000, 4'b1100, 0, "R12 up logical serial ignored");
    step(0, 2'b10, 2'b01, 1, 1, 4'b0000, 4'b1000, 1, "R12 up arith serial ignored");
    step(0, 2'b11, 2'b00, 0, 0, 4'b0111, 4'b0111, 1, "R3 load");
    step(0, 2'b01, 2'b10, 0, 0, 4'b0000, 4'b1011, 1, "R11 down shiftOut bit0");
    step(1, 2'b01, 2'b00, 0, 0, 4'b0000, 4'b0000, 0, "R1 reset beats shift");
    step(0, 2'b00, 2'b00, 0, 0, 4'b0000, 4'b0000, 0, "R2 hold after reset");
    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule